// File: doc/BRIEF.md
# Banked Packet Buffer Address Mapper

This block lets two masters share one 16-bit-wide packet buffer RAM. A LAN coprocessor issues full-word accesses on a wide byte address. Only the low 16 address bits count, so the coprocessor's top-of-memory start-up location folds down into the RAM. A host bus sees the RAM through a 16 KB window. A bank register, written through a dedicated port, picks which 16 KB slice of the RAM the window shows. The block maps each master's address to a RAM word address, picks one master per cycle and forwards the write data and byte strobes. After one cycle it returns the read data, or an error when the access was refused.

There are two builds. The 64 KB build (`LARGE_RAM=1`) exposes four banks. The 16 KB build (`LARGE_RAM=0`) has one physical slice, which appears as bank 3. In the 16 KB build the parameter `BANK_STRICT` selects what happens when the host uses another bank: either the access reaches the same 16 KB anyway, or it is refused with an error.

Both request interfaces are valid/ready. A request transfers on a cycle in which valid and ready are both high. While valid is high and ready is low, the master must hold its request unchanged. The coprocessor is never back-pressured. The host is back-pressured on every cycle in which the coprocessor requests. Responses cannot be stalled: each accepted request produces exactly one response pulse one cycle later. The RAM is expected to return read data one cycle after `ram_en`.

Top module: `pbm_top`

## Requirements
- R1: A coprocessor request maps to RAM byte address `cop_addr[15:0]` (64 KB build) or `cop_addr[13:0]` (16 KB build). `ram_addr` is that byte address shifted right by one. Address bits above bit 15 have no effect.
- R2: Coprocessor address 0xFFFFF6 reaches the same RAM word as a host access at window offset 0x3FF6 with bank 3 selected. That word is 0x7FFB in the 64 KB build and 0x1FFB in the 16 KB build.
- R3: In the 64 KB build, a host request maps to RAM byte address {bank, host_off[13:0]}, and `ram_addr` is that value shifted right by one.
- R4: In the 16 KB build, a host request maps to byte address `host_off[13:0]`. With `BANK_STRICT=0` this holds for every bank value. With `BANK_STRICT=1`, a bank other than 3 gives no RAM access and an error response.
- R5: A coprocessor request with `cop_be` other than 2'b11 (byte-wide) is accepted, gives no RAM access and returns an error response.
- R6: `cop_ready` is always 1. `host_ready` is low exactly while `cop_valid` is high. When both masters request, the coprocessor drives the RAM port.
- R7: Exactly one cycle after a request is accepted, that master's `*_rsp_valid` is high for one cycle. At the same time `*_rsp_err` shows whether the request was refused, and `*_rdata` carries `ram_rdata`.
- R8: A host access forwards `host_be` unchanged to `ram_be` (bit 0 is the low byte, bit 1 the high byte). A coprocessor access drives `ram_be` = 2'b11.
- R9: The bank register is 0 after reset. A cycle with `bank_we` high loads `bank_wdata`, and the new value shows on `bank_q` from the next cycle.
- R10: `ram_we` and `ram_wdata` come from the master that is granted, so data written by one master can be read back by the other at the aliased location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | BANK_W | New bank value |
| bank_q | output | BANK_W | Current bank |
| cop_valid | input | 1 | Coprocessor request valid |
| cop_ready | output | 1 | Coprocessor request ready (always 1) |
| cop_addr | input | CA_W | Coprocessor byte address |
| cop_we | input | 1 | Coprocessor write |
| cop_be | input | 2 | Coprocessor byte strobes (must be 2'b11) |
| cop_wdata | input | DW | Coprocessor write data |
| cop_rsp_valid | output | 1 | Coprocessor response pulse |
| cop_rsp_err | output | 1 | Coprocessor request was refused |
| cop_rdata | output | DW | Coprocessor read data |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request ready |
| host_off | input | HOST_OFF_W | Host byte offset inside the window |
| host_we | input | 1 | Host write |
| host_be | input | 2 | Host byte strobes |
| host_wdata | input | DW | Host write data |
| host_rsp_valid | output | 1 | Host response pulse |
| host_rsp_err | output | 1 | Host request was refused |
| host_rdata | output | DW | Host read data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write |
| ram_be | output | 2 | RAM byte strobes |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after ram_en |

## Verification
The bench drives three builds side by side: 64 KB, 16 KB with aliasing, and 16 KB strict. It sweeps coprocessor addresses that carry junk in the bits above bit 15. A mapper that used those bits, or kept the wrong number of low bits, would put the start-up vector somewhere other than word 0x7FFB or 0x1FFB. It also sweeps every bank against a spread of offsets. A strict build that still touched the RAM on a foreign bank, or an aliasing build that refused one, shows up in `ram_en` and in the error flag. Collisions, byte-wide coprocessor cycles and a word written at 0xFFFFF6 and then patched and read back by the host through bank 3 catch these faults: a priority flip, a byte cycle that leaks into the RAM, dropped strobes, or data taken from the wrong master.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  // Which master owns the RAM port on a given cycle
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_COP  = 2'd1,
    SRC_HOST = 2'd2
  } src_e;

  // Per-master request summary after address mapping
  typedef struct packed {
    logic       valid;
    logic       bad;
    logic       we;
    logic [1:0] be;
  } req_t;
endpackage

// File: rtl/pbm_cop_map.sv
module pbm_cop_map #(
  parameter int CA_W   = 24,
  parameter int RAM_AW = 15
) (
  input  logic              cop_valid,
  input  logic [CA_W-1:0]   cop_addr,
  input  logic              cop_we,
  input  logic [1:0]        cop_be,
  output pbm_pkg::req_t     req,
  output logic [RAM_AW-1:0] waddr
);
  // Only the bits that select a word in the physical RAM matter.
  // Everything above them wraps, so the high start-up vector lands inside the RAM.
  assign waddr = cop_addr[RAM_AW:1];

  logic unused_cop_bits;
  assign unused_cop_bits = ^{cop_addr[CA_W-1:RAM_AW+1], cop_addr[0]};

  always_comb begin
    req.valid = cop_valid;
    req.bad   = (cop_be != 2'b11);   // byte-wide coprocessor cycles are refused
    req.we    = cop_we;
    req.be    = 2'b11;
  end
endmodule

// File: rtl/pbm_host_map.sv
module pbm_host_map #(
  parameter bit LARGE_RAM   = 1'b1,
  parameter bit BANK_STRICT = 1'b0,
  parameter int HOST_OFF_W  = 14,
  parameter int BANK_W      = 2,
  parameter int RAM_AW      = 15
) (
  input  logic                  host_valid,
  input  logic [BANK_W-1:0]     bank,
  input  logic [HOST_OFF_W-1:0] host_off,
  input  logic                  host_we,
  input  logic [1:0]            host_be,
  output pbm_pkg::req_t         req,
  output logic [RAM_AW-1:0]     waddr
);
  logic bank_err;
  logic unused_host_bits;

  generate
    if (LARGE_RAM) begin : g_banked
      // Every bank is a distinct slice of the RAM
      assign waddr            = {bank, host_off[HOST_OFF_W-1:1]};
      assign bank_err         = 1'b0;
      assign unused_host_bits = host_off[0];
    end else begin : g_single
      // One physical slice; it is officially bank all-ones
      assign waddr = host_off[HOST_OFF_W-1:1];
      if (BANK_STRICT) begin : g_strict
        assign bank_err = (bank != {BANK_W{1'b1}});
      end else begin : g_alias
        assign bank_err = 1'b0;
      end
      assign unused_host_bits = ^{host_off[0], bank};
    end
  endgenerate

  always_comb begin
    req.valid = host_valid;
    req.bad   = bank_err;
    req.we    = host_we;
    req.be    = host_be;
  end
endmodule

// File: rtl/pbm_bank_reg.sv
module pbm_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [BANK_W-1:0] bank_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata;
  end

  // R9
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> (bank_q == $past(bank_wdata)));
  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q));
endmodule

// File: rtl/pbm_arbiter.sv
module pbm_arbiter #(
  parameter int RAM_AW = 15,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pbm_pkg::req_t     cop_req,
  input  logic [RAM_AW-1:0] cop_waddr,
  input  logic [DW-1:0]     cop_wdata,
  input  pbm_pkg::req_t     host_req,
  input  logic [RAM_AW-1:0] host_waddr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_ready,
  output logic              ram_en,
  output logic              ram_we,
  output logic [1:0]        ram_be,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              cop_rsp_valid,
  output logic              cop_rsp_err,
  output logic              host_rsp_valid,
  output logic              host_rsp_err
);
  import pbm_pkg::*;

  src_e owner;

  // Fixed priority: the coprocessor always wins
  always_comb begin
    if (cop_req.valid)       owner = SRC_COP;
    else if (host_req.valid) owner = SRC_HOST;
    else                     owner = SRC_NONE;
  end

  assign host_ready = !cop_req.valid;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_be    = 2'b00;
    ram_addr  = host_waddr;
    ram_wdata = host_wdata;
    unique case (owner)
      SRC_COP: begin
        ram_en    = !cop_req.bad;
        ram_we    = cop_req.we && !cop_req.bad;
        ram_be    = cop_req.be;
        ram_addr  = cop_waddr;
        ram_wdata = cop_wdata;
      end
      SRC_HOST: begin
        ram_en = !host_req.bad;
        ram_we = host_req.we && !host_req.bad;
        ram_be = host_req.be;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cop_rsp_valid  <= 1'b0;
      cop_rsp_err    <= 1'b0;
      host_rsp_valid <= 1'b0;
      host_rsp_err   <= 1'b0;
    end else begin
      cop_rsp_valid  <= (owner == SRC_COP);
      cop_rsp_err    <= (owner == SRC_COP) && cop_req.bad;
      host_rsp_valid <= (owner == SRC_HOST);
      host_rsp_err   <= (owner == SRC_HOST) && host_req.bad;
    end
  end

  // R6
  cop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_req.valid |-> (!host_ready && ram_addr == cop_waddr));
  // R7
  cop_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_req.valid |=> cop_rsp_valid);
  // R7
  host_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req.valid && host_ready) |=> host_rsp_valid);
  // R7
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cop_rsp_valid && host_rsp_valid));
  // R5
  cop_byte_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_req.valid && cop_req.bad) |-> (!ram_en ##1 cop_rsp_err));
endmodule

// File: rtl/pbm_top.sv
module pbm_top #(
  parameter bit LARGE_RAM   = 1'b1,
  parameter bit BANK_STRICT = 1'b0,
  parameter int CA_W        = 24,
  parameter int HOST_OFF_W  = 14,
  parameter int BANK_W      = 2,
  parameter int DW          = 16,
  localparam int RAM_AW     = LARGE_RAM ? (HOST_OFF_W + BANK_W - 1) : (HOST_OFF_W - 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bank_we,
  input  logic [BANK_W-1:0]     bank_wdata,
  output logic [BANK_W-1:0]     bank_q,
  input  logic                  cop_valid,
  output logic                  cop_ready,
  input  logic [CA_W-1:0]       cop_addr,
  input  logic                  cop_we,
  input  logic [1:0]            cop_be,
  input  logic [DW-1:0]         cop_wdata,
  output logic                  cop_rsp_valid,
  output logic                  cop_rsp_err,
  output logic [DW-1:0]         cop_rdata,
  input  logic                  host_valid,
  output logic                  host_ready,
  input  logic [HOST_OFF_W-1:0] host_off,
  input  logic                  host_we,
  input  logic [1:0]            host_be,
  input  logic [DW-1:0]         host_wdata,
  output logic                  host_rsp_valid,
  output logic                  host_rsp_err,
  output logic [DW-1:0]         host_rdata,
  output logic                  ram_en,
  output logic                  ram_we,
  output logic [1:0]            ram_be,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic [DW-1:0]         ram_wdata,
  input  logic [DW-1:0]         ram_rdata
);
  pbm_pkg::req_t     cop_req, host_req;
  logic [RAM_AW-1:0] cop_waddr, host_waddr;

  assign cop_ready  = 1'b1;
  assign cop_rdata  = ram_rdata;
  assign host_rdata = ram_rdata;

  pbm_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .bank_q(bank_q)
  );

  pbm_cop_map #(.CA_W(CA_W), .RAM_AW(RAM_AW)) u_cop (
    .cop_valid(cop_valid), .cop_addr(cop_addr), .cop_we(cop_we),
    .cop_be(cop_be), .req(cop_req), .waddr(cop_waddr)
  );

  pbm_host_map #(
    .LARGE_RAM(LARGE_RAM), .BANK_STRICT(BANK_STRICT),
    .HOST_OFF_W(HOST_OFF_W), .BANK_W(BANK_W), .RAM_AW(RAM_AW)
  ) u_host (
    .host_valid(host_valid), .bank(bank_q), .host_off(host_off),
    .host_we(host_we), .host_be(host_be), .req(host_req), .waddr(host_waddr)
  );

  pbm_arbiter #(.RAM_AW(RAM_AW), .DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .cop_req(cop_req), .cop_waddr(cop_waddr), .cop_wdata(cop_wdata),
    .host_req(host_req), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_ready(host_ready),
    .ram_en(ram_en), .ram_we(ram_we), .ram_be(ram_be),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .cop_rsp_valid(cop_rsp_valid), .cop_rsp_err(cop_rsp_err),
    .host_rsp_valid(host_rsp_valid), .host_rsp_err(host_rsp_err)
  );

  // R1
  cop_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cop_valid && cop_be == 2'b11) |-> (ram_en && ram_addr == cop_addr[RAM_AW:1]));
  // R8
  host_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && ram_en) |-> (ram_be == host_be));
  // R10
  host_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && ram_we) |-> (ram_wdata == host_wdata && host_we));
endmodule

// File: tb/tb_pbm_top.sv
`timescale 1ns/1ps
module tb_pbm_ram #(parameter int AW = 15) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata
);
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  always @(posedge clk) begin
    if (en) begin
      rdata <= mem[addr[7:0]];
      if (we && be[0]) mem[addr[7:0]][7:0]  <= wdata[7:0];
      if (we && be[1]) mem[addr[7:0]][15:8] <= wdata[15:8];
    end
  end
endmodule

module tb_pbm_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bank_we = 0; logic [1:0] bank_wdata = 0;
  logic        cv = 0, cwe = 0; logic [23:0] ca = 0; logic [1:0] cbe = 2'b11; logic [15:0] cwd = 0;
  logic        hv = 0, hwe = 0; logic [13:0] ho = 0; logic [1:0] hbe = 2'b11; logic [15:0] hwd = 0;

  // three builds: w = 64 KB, a = 16 KB aliasing, s = 16 KB strict
  logic [1:0]  bq_w, bq_a, bq_s;
  logic        cr_w, cr_a, cr_s, hr_w, hr_a, hr_s;
  logic        crv_w, crv_a, crv_s, cre_w, cre_a, cre_s;
  logic        hrv_w, hrv_a, hrv_s, hre_w, hre_a, hre_s;
  logic [15:0] crd_w, crd_a, crd_s, hrd_w, hrd_a, hrd_s;
  logic        en_w, en_a, en_s, we_w, we_a, we_s;
  logic [1:0]  be_w, be_a, be_s;
  logic [14:0] ad_w; logic [12:0] ad_a, ad_s;
  logic [15:0] wd_w, wd_a, wd_s, rd_w, rd_a, rd_s;

  pbm_top #(.LARGE_RAM(1'b1), .BANK_STRICT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bq_w),
    .cop_valid(cv), .cop_ready(cr_w), .cop_addr(ca), .cop_we(cwe), .cop_be(cbe), .cop_wdata(cwd),
    .cop_rsp_valid(crv_w), .cop_rsp_err(cre_w), .cop_rdata(crd_w),
    .host_valid(hv), .host_ready(hr_w), .host_off(ho), .host_we(hwe), .host_be(hbe), .host_wdata(hwd),
    .host_rsp_valid(hrv_w), .host_rsp_err(hre_w), .host_rdata(hrd_w),
    .ram_en(en_w), .ram_we(we_w), .ram_be(be_w), .ram_addr(ad_w), .ram_wdata(wd_w), .ram_rdata(rd_w));
  pbm_top #(.LARGE_RAM(1'b0), .BANK_STRICT(1'b0)) dut_a (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bq_a),
    .cop_valid(cv), .cop_ready(cr_a), .cop_addr(ca), .cop_we(cwe), .cop_be(cbe), .cop_wdata(cwd),
    .cop_rsp_valid(crv_a), .cop_rsp_err(cre_a), .cop_rdata(crd_a),
    .host_valid(hv), .host_ready(hr_a), .host_off(ho), .host_we(hwe), .host_be(hbe), .host_wdata(hwd),
    .host_rsp_valid(hrv_a), .host_rsp_err(hre_a), .host_rdata(hrd_a),
    .ram_en(en_a), .ram_we(we_a), .ram_be(be_a), .ram_addr(ad_a), .ram_wdata(wd_a), .ram_rdata(rd_a));
  pbm_top #(.LARGE_RAM(1'b0), .BANK_STRICT(1'b1)) dut_s (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bq_s),
    .cop_valid(cv), .cop_ready(cr_s), .cop_addr(ca), .cop_we(cwe), .cop_be(cbe), .cop_wdata(cwd),
    .cop_rsp_valid(crv_s), .cop_rsp_err(cre_s), .cop_rdata(crd_s),
    .host_valid(hv), .host_ready(hr_s), .host_off(ho), .host_we(hwe), .host_be(hbe), .host_wdata(hwd),
    .host_rsp_valid(hrv_s), .host_rsp_err(hre_s), .host_rdata(hrd_s),
    .ram_en(en_s), .ram_we(we_s), .ram_be(be_s), .ram_addr(ad_s), .ram_wdata(wd_s), .ram_rdata(rd_s));

  tb_pbm_ram #(.AW(15)) ram_w (.clk(clk), .en(en_w), .we(we_w), .be(be_w), .addr(ad_w), .wdata(wd_w), .rdata(rd_w));
  tb_pbm_ram #(.AW(13)) ram_a (.clk(clk), .en(en_a), .we(we_a), .be(be_a), .addr(ad_a), .wdata(wd_a), .rdata(rd_a));
  tb_pbm_ram #(.AW(13)) ram_s (.clk(clk), .en(en_s), .we(we_s), .be(be_s), .addr(ad_s), .wdata(wd_s), .rdata(rd_s));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_bank(input logic [1:0] b);
    @(negedge clk); bank_we = 1; bank_wdata = b;
    @(negedge clk); bank_we = 0;
  endtask

  // Coprocessor access: check the RAM port in the request cycle, the response one cycle later
  task automatic cop_probe(input logic [23:0] a, input logic [1:0] be, input logic we, input logic [15:0] d);
    logic bad;
    bad = (be != 2'b11);
    @(negedge clk); cv = 1; ca = a; cbe = be; cwe = we; cwd = d;
    #2;
    chk(cr_w && cr_a && cr_s, "R6 cop_ready", {cr_w, cr_a, cr_s}, 3'b111);
    chk(en_w == !bad && en_a == !bad && en_s == !bad, "R5 ram_en", {en_w, en_a, en_s}, {3{!bad}});
    if (!bad) begin
      chk(ad_w == a[15:1], "R1 addr 64K", ad_w, a[15:1]);
      chk(ad_a == a[13:1] && ad_s == a[13:1], "R1 addr 16K", {ad_a, ad_s}, {a[13:1], a[13:1]});
      chk(be_w == 2'b11 && be_a == 2'b11, "R8 cop strobes", {be_w, be_a}, 4'hF);
    end
    @(negedge clk); cv = 0; cbe = 2'b11; cwe = 0;
    chk(crv_w && crv_a && crv_s, "R7 cop rsp_valid", {crv_w, crv_a, crv_s}, 3'b111);
    chk(cre_w == bad && cre_a == bad && cre_s == bad, "R5 cop rsp_err", {cre_w, cre_a, cre_s}, {3{bad}});
  endtask

  task automatic host_probe(input logic [1:0] b, input logic [13:0] off, input logic [1:0] be,
                            input logic we, input logic [15:0] d);
    logic serr;
    serr = (b != 2'd3);
    @(negedge clk); hv = 1; ho = off; hbe = be; hwe = we; hwd = d;
    #2;
    chk(hr_w && hr_a && hr_s, "R6 host_ready idle", {hr_w, hr_a, hr_s}, 3'b111);
    chk(en_w && ad_w == {b, off[13:1]}, "R3 host addr 64K", {en_w, ad_w}, {1'b1, b, off[13:1]});
    chk(en_a && ad_a == off[13:1], "R4 host alias", {en_a, ad_a}, {1'b1, off[13:1]});
    chk(en_s == !serr, "R4 strict ram_en", en_s, !serr);
    if (!serr) chk(ad_s == off[13:1], "R4 strict addr", ad_s, off[13:1]);
    chk(be_w == be && be_a == be, "R8 host strobes", {be_w, be_a}, {be, be});
    @(negedge clk); hv = 0; hwe = 0;
    chk(hrv_w && hrv_a && hrv_s, "R7 host rsp_valid", {hrv_w, hrv_a, hrv_s}, 3'b111);
    chk(!hre_w && !hre_a && hre_s == serr, "R4 host rsp_err", {hre_w, hre_a, hre_s}, {2'b00, serr});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R9 reset state
    chk(bq_w == 0 && bq_a == 0 && bq_s == 0, "R9 bank reset", {bq_w, bq_a, bq_s}, 0);
    chk(!en_w && !crv_w && !hrv_w, "R7 idle after reset", {en_w, crv_w, hrv_w}, 0);
    @(negedge clk); rst_n = 1;

    // R9 bank load
    set_bank(2'd2);
    #2 chk(bq_w == 2 && bq_s == 2, "R9 bank load", {bq_w, bq_s}, {2'd2, 2'd2});

    // R1 coprocessor sweep with junk in the upper bits
    for (int i = 0; i < 256; i++) begin
      logic [23:0] a;
      a = {8'(i * 37 + 5), 16'(i * 257 + i * 2)};
      cop_probe(a, 2'b11, 1'b0, 16'h0);
    end

    // R5 byte-wide coprocessor cycles are refused
    cop_probe(24'h00C002, 2'b01, 1'b1, 16'hDEAD);
    cop_probe(24'h00C002, 2'b10, 1'b1, 16'hDEAD);
    cop_probe(24'h00C002, 2'b00, 1'b0, 16'h0);

    // R2 start-up vector: coprocessor word write at 0xFFFFF6
    @(negedge clk); cv = 1; ca = 24'hFFFFF6; cbe = 2'b11; cwe = 1; cwd = 16'hA5C3;
    #2 chk(ad_w == 15'h7FFB && ad_a == 13'h1FFB, "R2 vector word", {ad_w, ad_a}, {15'h7FFB, 13'h1FFB});
    @(negedge clk); cv = 0; cwe = 0;

    // R3 R4 host sweep: every bank, a spread of offsets
    for (int b = 0; b < 4; b++) begin
      set_bank(2'(b));
      for (int k = 0; k < 64; k++) host_probe(2'(b), 14'(k * 251 + b), 2'b11, 1'b0, 16'h0);
    end

    // R8 R10 host patches the high byte of the vector through bank 3, then reads it back
    set_bank(2'd3);
    host_probe(2'd3, 14'h3FF7, 2'b10, 1'b1, 16'h1100);
    @(negedge clk); hv = 1; ho = 14'h3FF6; hbe = 2'b11; hwe = 0;
    @(negedge clk); hv = 0;
    chk(hrd_w == 16'h11C3 && hrd_a == 16'h11C3 && hrd_s == 16'h11C3, "R10 R2 readback",
        {hrd_w, hrd_s}, {16'h11C3, 16'h11C3});

    // R6 collision: coprocessor wins, host stalls then goes next
    @(negedge clk); cv = 1; ca = 24'h12C010; cwe = 0; hv = 1; ho = 14'h0020; hwe = 0;
    #2;
    chk(!hr_w && !hr_a && !hr_s, "R6 host stalled", {hr_w, hr_a, hr_s}, 0);
    chk(ad_w == 15'h6008, "R6 cop owns ram", ad_w, 15'h6008);
    @(negedge clk); cv = 0;
    chk(crv_w && !hrv_w, "R6 cop served first", {crv_w, hrv_w}, 2'b10);
    #2 chk(hr_w && ad_w == {2'd3, 13'h0010}, "R6 host after cop", {hr_w, ad_w}, {1'b1, 2'd3, 13'h0010});
    @(negedge clk); hv = 0;
    chk(hrv_w && !crv_w, "R7 host served second", {hrv_w, crv_w}, 2'b10);
    @(negedge clk);
    chk(!hrv_w && !crv_w, "R7 single pulse", {hrv_w, crv_w}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule